// File: doc/BRIEF.md
# Universal Shift Register with Set and Clear Controls

This block holds a word of parameterizable width that can be shifted one position per clock, loaded in parallel, or forced to fixed values. The shift direction is chosen at elaboration. A serial bit enters at one end of the word, and the bit at the opposite end is presented on a serial output. The whole word is always visible on a parallel output. All clocked work is gated by an active-high clock enable.

Two kinds of forcing control are provided. The asynchronous pair acts at once without a clock and overrides everything else. The synchronous pair acts only on an enabled clock edge. Each set control forces the word to its own elaboration-time constant, which is all ones by default. There is also a synchronous active-low reset that clears the word on any clock edge.

Top module: `univ_shreg`

## Requirements
- R1: With SHIFT_LEFT=1, on an enabled edge with no higher-priority action, `sin` enters bit 0 and every bit k moves to bit k+1. The old top bit is discarded.
- R2: With SHIFT_LEFT=0, on an enabled edge with no higher-priority action, `sin` enters bit WIDTH-1 and every bit k moves to bit k-1. The old bit 0 is discarded.
- R3: `sout` equals `q[WIDTH-1]` in left mode and `q[0]` in right mode, at all times.
- R4: On an enabled edge, `load` high copies `din` into `q`. Load takes priority over shifting, and it never acts without a clock edge.
- R5: With `ena` low and `rst_n` high, a clock edge leaves `q` unchanged, whatever `sclr`, `sset`, `load` and `sin` are.
- R6: On an enabled edge, `sclr` high makes `q` all zeros. This wins over `sset`, `load` and shifting.
- R7: On an enabled edge with `sclr` low, `sset` high makes `q` equal SSET_VALUE (all ones by default). This wins over `load` and shifting.
- R8: `aclr` high forces `q` to zero at once, with no clock edge and whatever `ena` is. It wins over `aset`.
- R9: `aset` high with `aclr` low forces `q` to ASET_VALUE (all ones by default) at once, with no clock edge.
- R10: `rst_n` low clears `q` on a clock edge whatever `ena` is. The asynchronous controls override it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ena | input | 1 | Clock enable for clocked actions |
| aclr | input | 1 | Asynchronous clear, active high |
| aset | input | 1 | Asynchronous set to ASET_VALUE, active high |
| sclr | input | 1 | Synchronous clear, active high |
| sset | input | 1 | Synchronous set to SSET_VALUE, active high |
| load | input | 1 | Parallel load strobe |
| sin | input | 1 | Serial data input |
| din | input | WIDTH | Parallel data input |
| q | output | WIDTH | Register contents |
| sout | output | 1 | Serial data output |

## Verification
Two 4-bit instances, one per shift direction, receive the same stimulus. Each has distinct set constants, so a swapped constant or a swapped direction shows up at once. An exhaustive sweep walks every combination of the six clocked control bits together with every `din` value. This separates each priority pair, for example clear against set and load against shift, and it also exposes enable-low holds. A pseudo-random run with long shift stretches checks that serial data travels end to end. Directed sequences between edges check immediate asynchronous action, clear beating set, and the word holding once both asynchronous controls are released.

// File: rtl/univ_shreg_pkg.sv
// Package: shared action encoding for the universal shift register.
// Assumes: one clocked action is chosen per edge.
package univ_shreg_pkg;

    typedef enum logic [2:0] {
        ACT_HOLD  = 3'd0,
        ACT_ZERO  = 3'd1,
        ACT_SETW  = 3'd2,
        ACT_LOAD  = 3'd3,
        ACT_SHIFT = 3'd4
    } shreg_act_t;

endpackage

// File: rtl/univ_shreg_ctrl.sv
// Module: univ_shreg_ctrl
// Picks the one clocked action for the coming edge from the synchronous
// controls. Priority: reset, then the enable gate, then clear, set, load,
// and finally shift.
// Assumes: the asynchronous controls are handled in the state register.
module univ_shreg_ctrl
    import univ_shreg_pkg::*;
(
    input  logic       rst_n,
    input  logic       ena,
    input  logic       sclr,
    input  logic       sset,
    input  logic       load,
    output shreg_act_t act
);

    // Priority decode of the synchronous controls
    always_comb begin
        if (!rst_n)     act = ACT_ZERO;
        else if (!ena)  act = ACT_HOLD;
        else if (sclr)  act = ACT_ZERO;
        else if (sset)  act = ACT_SETW;
        else if (load)  act = ACT_LOAD;
        else            act = ACT_SHIFT;
    end

endmodule

// File: rtl/univ_shreg_next.sv
// Module: univ_shreg_next
// Computes the next register word for a given action. It also selects the
// serial output bit, with the direction fixed by SHIFT_LEFT.
// Assumes: WIDTH >= 1.
module univ_shreg_next
    import univ_shreg_pkg::*;
#(
    parameter int                 WIDTH      = 8,
    parameter bit                 SHIFT_LEFT = 1'b1,
    parameter logic [WIDTH-1:0]   SSET_VALUE = '1
) (
    input  shreg_act_t       act,
    input  logic [WIDTH-1:0] cur,
    input  logic             sin,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] nxt,
    output logic             sout
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] shifted;

    // Shift network and serial tap, chosen by direction and width
    generate
        if (WIDTH == 1) begin : g_one
            assign shifted = sin;
            assign sout    = cur[0];
        end else if (SHIFT_LEFT) begin : g_left
            assign shifted = {cur[MSB-1:0], sin};
            assign sout    = cur[MSB];
        end else begin : g_right
            assign shifted = {sin, cur[MSB:1]};
            assign sout    = cur[0];
        end
    endgenerate

    // Next-word multiplexer driven by the decoded action
    always_comb begin
        unique case (act)
            ACT_ZERO:  nxt = '0;
            ACT_SETW:  nxt = SSET_VALUE;
            ACT_LOAD:  nxt = din;
            ACT_SHIFT: nxt = shifted;
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/univ_shreg.sv
// Module: univ_shreg (top)
// Universal shift register. Asynchronous clear/set act at once, with clear
// dominant. The synchronous actions are chosen by univ_shreg_ctrl and
// formed by univ_shreg_next.
// Assumes: WIDTH >= 1; asynchronous inputs come from glitch-free sources.
module univ_shreg
    import univ_shreg_pkg::*;
#(
    parameter int                 WIDTH      = 8,
    parameter bit                 SHIFT_LEFT = 1'b1,
    parameter logic [WIDTH-1:0]   ASET_VALUE = '1,
    parameter logic [WIDTH-1:0]   SSET_VALUE = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ena,
    input  logic             aclr,
    input  logic             aset,
    input  logic             sclr,
    input  logic             sset,
    input  logic             load,
    input  logic             sin,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] q,
    output logic             sout
);

    localparam int MSB = WIDTH - 1;

    shreg_act_t       act;
    logic [WIDTH-1:0] q_nxt;

    univ_shreg_ctrl u_ctrl (
        .rst_n (rst_n),
        .ena   (ena),
        .sclr  (sclr),
        .sset  (sset),
        .load  (load),
        .act   (act)
    );

    univ_shreg_next #(
        .WIDTH      (WIDTH),
        .SHIFT_LEFT (SHIFT_LEFT),
        .SSET_VALUE (SSET_VALUE)
    ) u_next (
        .act  (act),
        .cur  (q),
        .sin  (sin),
        .din  (din),
        .nxt  (q_nxt),
        .sout (sout)
    );

    // State register: asynchronous clear over asynchronous set over clocked update
    always_ff @(posedge clk or posedge aclr or posedge aset) begin
        if (aclr)      q <= '0;
        else if (aset) q <= ASET_VALUE;
        else           q <= q_nxt;
    end

    // Assertions guarding the clocked behaviour
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n || aclr || aset)
        !ena |=> $stable(q));

    p_sclr_r6: assert property (@(posedge clk) disable iff (!rst_n || aclr || aset)
        (ena && sclr) |=> (q == '0));

    p_sset_r7: assert property (@(posedge clk) disable iff (!rst_n || aclr || aset)
        (ena && !sclr && sset) |=> (q == SSET_VALUE));

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n || aclr || aset)
        (ena && !sclr && !sset && load) |=> (q == $past(din)));

    p_rst_r10: assert property (@(posedge clk) disable iff (aclr || aset)
        !rst_n |=> (q == '0));

    generate
        if (WIDTH > 1 && SHIFT_LEFT) begin : g_chk_left
            p_shift_left_r1: assert property (@(posedge clk)
                disable iff (!rst_n || aclr || aset)
                (ena && !sclr && !sset && !load)
                |=> (q == {$past(q[MSB-1:0]), $past(sin)}));
        end else if (WIDTH > 1) begin : g_chk_right
            p_shift_right_r2: assert property (@(posedge clk)
                disable iff (!rst_n || aclr || aset)
                (ena && !sclr && !sset && !load)
                |=> (q == {$past(sin), $past(q[MSB:1])}));
        end
    endgenerate

endmodule

// File: tb/univ_shreg_bench.sv
`timescale 1ns/100ps
module univ_shreg_bench;

    localparam int W = 4;
    localparam logic [W-1:0] L_ASET = 4'hA;
    localparam logic [W-1:0] L_SSET = 4'hF;
    localparam logic [W-1:0] R_ASET = 4'hF;
    localparam logic [W-1:0] R_SSET = 4'h5;

    logic clk = 1'b0;
    logic rst_n, ena, aclr, aset, sclr, sset, load, sin;
    logic [W-1:0] din;
    logic [W-1:0] q_l, q_r;
    logic sout_l, sout_r;

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] m_l, m_r;

    always #2.5 clk = ~clk;

    univ_shreg #(.WIDTH(W), .SHIFT_LEFT(1'b1), .ASET_VALUE(L_ASET), .SSET_VALUE(L_SSET)) u_univ_shreg (
        .clk(clk), .rst_n(rst_n), .ena(ena), .aclr(aclr), .aset(aset), .sclr(sclr),
        .sset(sset), .load(load), .sin(sin), .din(din), .q(q_l), .sout(sout_l));

    univ_shreg #(.WIDTH(W), .SHIFT_LEFT(1'b0), .ASET_VALUE(R_ASET), .SSET_VALUE(R_SSET)) u_univ_shreg_r (
        .clk(clk), .rst_n(rst_n), .ena(ena), .aclr(aclr), .aset(aset), .sclr(sclr),
        .sset(sset), .load(load), .sin(sin), .din(din), .q(q_r), .sout(sout_r));

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
        end
    endtask

    function automatic string tag(input logic [W-1:0] start, input logic left);
        if (!rst_n) return "R10";
        if (!ena) return "R5";
        if (sclr) return "R6";
        if (sset) return "R7";
        if (load) return "R4";
        return left ? "R1" : "R2";
    endfunction

    function automatic logic [W-1:0] model(input logic [W-1:0] cur, input logic left,
                                           input logic [W-1:0] setv);
        if (!rst_n) return '0;
        if (!ena) return cur;
        if (sclr) return '0;
        if (sset) return setv;
        if (load) return din;
        return left ? {cur[W-2:0], sin} : {sin, cur[W-1:1]};
    endfunction

    // One clocked step: inputs already driven; compare after the edge
    task automatic step();
        string tl, tr;
        @(posedge clk);
        tl = tag(m_l, 1'b1);
        tr = tag(m_r, 1'b0);
        m_l = model(m_l, 1'b1, L_SSET);
        m_r = model(m_r, 1'b0, R_SSET);
        @(negedge clk);
        chk(tl, q_l, m_l);
        chk(tr, q_r, m_r);
        chk("R3", {3'b0, sout_l}, {3'b0, m_l[W-1]});
        chk("R3", {3'b0, sout_r}, {3'b0, m_r[0]});
    endtask

    initial begin : watchdog
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [15:0] lfsr;
        rst_n = 0; ena = 0; aclr = 0; aset = 0; sclr = 0; sset = 0; load = 0; sin = 0; din = '0;
        m_l = 'x; m_r = 'x;
        @(negedge clk);
        step();                      // R10 reset clears without enable
        chk("R10", q_l, '0);
        chk("R10", q_r, '0);

        // Exhaustive sweep of clocked controls and din (R1 R2 R4 R5 R6 R7 R10)
        for (int c = 0; c < 64; c++) begin
            for (int d = 0; d < 16; d++) begin
                {rst_n, ena, sclr, sset, load, sin} = 6'(c) ^ 6'b100000;
                din = 4'(d);
                step();
            end
        end

        // Pseudo-random run biased toward shifting (R1 R2 R3)
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rst_n = (lfsr[3:0] != 0);
            ena   = (lfsr[6:4] != 0);
            sclr  = (lfsr[9:7] == 0);
            sset  = (lfsr[11:9] == 7);
            load  = (lfsr[13:12] == 0);
            sin   = lfsr[14];
            din   = lfsr[W-1:0] ^ lfsr[15:12];
            step();
        end

        // Load a known word, then check R5 hold with every other control active
        rst_n = 1; ena = 1; sclr = 0; sset = 0; load = 1; din = 4'h6;
        step();
        ena = 0; sclr = 1; sset = 1; load = 1; sin = 1; din = 4'h9;
        step();
        chk("R5", q_l, 4'h6);
        chk("R5", q_r, 4'h6);

        // Asynchronous controls between edges, with reset held low so clocked checks idle
        rst_n = 0; ena = 0; sclr = 0; sset = 0; load = 0;
        @(negedge clk);
        m_l = '0; m_r = '0;
        #0.2 aset = 1;
        #0.2 chk("R9", q_l, L_ASET); chk("R9", q_r, R_ASET);
        aset = 0;
        #0.2 chk("R9", q_l, L_ASET); chk("R9", q_r, R_ASET);
        aclr = 1;
        #0.2 chk("R8", q_l, '0); chk("R8", q_r, '0);
        aset = 1;
        #0.2 chk("R8", q_l, '0); chk("R8", q_r, '0);
        aset = 0;
        #0.2 aclr = 0;
        #0.2 chk("R8", q_l, '0); chk("R8", q_r, '0);

        // Asynchronous set overrides a held reset on the following edge
        aset = 1;
        @(posedge clk);
        #0.5 chk("R10", q_l, L_ASET); chk("R10", q_r, R_ASET);
        @(negedge clk);
        aset = 0;
        step();                      // reset now clears
        chk("R10", q_l, '0);

        // Right-mode serial traversal: one bit travels from MSB to sout (R2 R3)
        rst_n = 1; ena = 1; sin = 1;
        step();
        sin = 0;
        for (int k = 0; k < W - 1; k++) step();
        chk("R3", {3'b0, sout_r}, 4'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule